// File: doc/BRIEF.md
# Strided Cell Destination Address Generator

This block produces the destination start address of each cell in a multi-cell DMA transfer. A cell is a contiguous run of bytes. Each channel has a 16-bit stride register that sets the gap between the end of one cell and the start of the next. A transfer controller starts a channel by pulsing `startPulse` with an initial address. After that, each `cellDone` pulse moves that channel's address on by one cell step: the cell size plus the stride. A stride of zero means the stride equals the cell size.

Software reaches the sixteen stride registers over a plain register bus. The registers can be read at any time. Writes are refused while the channel is enabled. On every cell step the block also compares the stride with the transfer-width code. If the stride is misaligned for that width, it raises a sticky error flag for the channel. The address still advances by the stride exactly as programmed.

Top module: `dma_cell_addr_gen`

## Requirements
- R1: After reset, every stride register reads 0, every channel address is 0 and every `cfgErr` bit is 0.
- R2: A write to byte address 0x74 + k*0x50 stores `regWrData[15:0]` in the stride of channel k. Reading that address returns the stride in bits 15:0, with bits 31:16 always zero.
- R3: A stride write to channel k while `chEnable[k]` is 1 is ignored. Reads of that channel still work while it is enabled.
- R4: `startPulse` loads `startAddr` into the channel selected by `chSel` and clears that channel's `cfgErr` bit, both visible after the next clock edge.
- R5: `cellDone` adds `cellSize` plus the stride to the selected channel's address, visible after the next clock edge.
- R6: When the stride is 0, `cellDone` adds twice `cellSize`.
- R7: With width code 3'b001 or 3'b100, a step whose stride has bit 0 set sets `cfgErr` for that channel. The bit stays set until the next `startPulse` for that channel, and the address is still advanced using the stride as written.
- R8: With width code 3'b101, a step whose stride has a nonzero value in bits 1:0 sets `cfgErr`.
- R9: With width code 3'b010, a nonzero value in stride bits 1:0 sets `cfgErr` only when `wordOnly` is 1. All other width codes never set `cfgErr`.
- R10: Address arithmetic is 32 bits and wraps modulo 2^32.
- R11: When `startPulse` and `cellDone` arrive in the same cycle, the start load wins.
- R12: A write to an address that matches no stride register changes nothing. Reading such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| chEnable | input | 16 | Per-channel enable; blocks stride writes |
| chSel | input | 4 | Channel addressed by start, step and `cellAddr` |
| startPulse | input | 1 | Load `startAddr` into the selected channel |
| startAddr | input | 32 | Initial destination address |
| cellDone | input | 1 | Current cell of the selected channel finished |
| cellSize | input | 16 | Cell size in bytes |
| widthCode | input | 3 | Transfer-width code for the alignment check |
| wordOnly | input | 1 | Word-only transfers requested (used with code 3'b010) |
| cellAddr | output | 32 | Current cell start address of the selected channel |
| cfgErr | output | 16 | Sticky per-channel stride alignment error |

## Verification
Some properties are checked by the assertions on every cycle. Reads always return zero in bits 31:16. An enabled write to channel 0 leaves its readback unchanged. A start loads the given address and clears the error bit. An error bit falls only on a start for that channel. The address sums need the bench's scenarios: stride plus size, the doubled size for a zero stride, and the wrap past 2^32. So do the per-width alignment outcomes and the priority of start over step.

// File: rtl/dma_cell_addr_pkg.sv
package dma_cell_addr_pkg;
  localparam int unsigned CH_IDX_W = 8;

  typedef struct packed {
    logic                strideWe;
    logic [CH_IDX_W-1:0] strideCh;
    logic                rdHit;
    logic [CH_IDX_W-1:0] rdCh;
    logic                addrLoad;
    logic                addrStep;
    logic                errSet;
  } ctlStrobes_t;
endpackage

// File: rtl/dma_cell_addr_ctrl.sv
module dma_cell_addr_ctrl
  import dma_cell_addr_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int REG_AW    = 12,
  parameter int REG_BASE  = 'h74,
  parameter int REG_PITCH = 'h50,
  parameter int STRIDE_W  = 16,
  localparam int SEL_W    = $clog2(NUM_CH)
) (
  input  logic [REG_AW-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [NUM_CH-1:0]   chEnable,
  input  logic [SEL_W-1:0]    chSel,
  input  logic                startPulse,
  input  logic                cellDone,
  input  logic [2:0]          widthCode,
  input  logic                wordOnly,
  input  logic [STRIDE_W-1:0] selStride,
  output ctlStrobes_t         strobes
);
  logic                hit;
  logic [CH_IDX_W-1:0] hitIdx;
  logic                protectedCh;
  logic                halfAlignReq;
  logic                wordAlignReq;
  logic                misaligned;

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == REG_AW'(REG_BASE + i * REG_PITCH)) begin
        hit    = 1'b1;
        hitIdx = CH_IDX_W'(i);
      end
    end
  end

  assign protectedCh  = chEnable[SEL_W'(hitIdx)];
  assign halfAlignReq = (widthCode == 3'b001) || (widthCode == 3'b100);
  assign wordAlignReq = (widthCode == 3'b101) || ((widthCode == 3'b010) && wordOnly);
  assign misaligned   = (halfAlignReq && selStride[0]) ||
                        (wordAlignReq && (selStride[1:0] != 2'b00));

  always_comb begin
    strobes.strideWe = regWrEn && hit && !protectedCh;
    strobes.strideCh = hitIdx;
    strobes.rdHit    = hit;
    strobes.rdCh     = hitIdx;
    strobes.addrLoad = startPulse;
    strobes.addrStep = cellDone && !startPulse;
    strobes.errSet   = cellDone && !startPulse && misaligned;
  end
endmodule

// File: rtl/dma_cell_addr_dp.sv
module dma_cell_addr_dp
  import dma_cell_addr_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int SIZE_W   = 16,
  localparam int SEL_W   = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [SEL_W-1:0]    chSel,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [SIZE_W-1:0]   cellSize,
  output logic [DATA_W-1:0]   regRdData,
  output logic [STRIDE_W-1:0] selStride,
  output logic [ADDR_W-1:0]   cellAddr,
  output logic [NUM_CH-1:0]   cfgErr
);
  logic [STRIDE_W-1:0] strideQ [NUM_CH];
  logic [ADDR_W-1:0]   addrQ   [NUM_CH];
  logic [ADDR_W-1:0]   stepAmt;
  logic [ADDR_W-1:0]   nextAddr;

  assign selStride = strideQ[chSel];
  assign cellAddr  = addrQ[chSel];
  assign stepAmt   = (selStride == '0) ? ADDR_W'(cellSize) : ADDR_W'(selStride);
  assign nextAddr  = addrQ[chSel] + ADDR_W'(cellSize) + stepAmt;
  assign regRdData = strobes.rdHit ? DATA_W'(strideQ[SEL_W'(strobes.rdCh)]) : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        strideQ[g] <= '0;
        addrQ[g]   <= '0;
        cfgErr[g]  <= 1'b0;
      end else begin
        if (strobes.strideWe && (SEL_W'(strobes.strideCh) == SEL_W'(g)))
          strideQ[g] <= regWrData[STRIDE_W-1:0];
        if (chSel == SEL_W'(g)) begin
          if (strobes.addrLoad) begin
            addrQ[g]  <= startAddr;
            cfgErr[g] <= 1'b0;
          end else if (strobes.addrStep) begin
            addrQ[g] <= nextAddr;
            if (strobes.errSet) cfgErr[g] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_cell_addr_gen.sv
module dma_cell_addr_gen
  import dma_cell_addr_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int STRIDE_W  = 16,
  parameter int SIZE_W    = 16,
  parameter int REG_AW    = 12,
  parameter int REG_BASE  = 'h74,
  parameter int REG_PITCH = 'h50,
  localparam int SEL_W    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [SEL_W-1:0]  chSel,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              cellDone,
  input  logic [SIZE_W-1:0] cellSize,
  input  logic [2:0]        widthCode,
  input  logic              wordOnly,
  output logic [ADDR_W-1:0] cellAddr,
  output logic [NUM_CH-1:0] cfgErr
);
  ctlStrobes_t         strobes;
  logic [STRIDE_W-1:0] selStride;

  dma_cell_addr_ctrl #(
    .NUM_CH(NUM_CH), .REG_AW(REG_AW), .REG_BASE(REG_BASE),
    .REG_PITCH(REG_PITCH), .STRIDE_W(STRIDE_W)
  ) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .chEnable(chEnable),
    .chSel(chSel), .startPulse(startPulse), .cellDone(cellDone),
    .widthCode(widthCode), .wordOnly(wordOnly), .selStride(selStride),
    .strobes(strobes)
  );

  dma_cell_addr_dp #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STRIDE_W(STRIDE_W), .SIZE_W(SIZE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .chSel(chSel), .startAddr(startAddr), .cellSize(cellSize),
    .regRdData(regRdData), .selStride(selStride), .cellAddr(cellAddr),
    .cfgErr(cfgErr)
  );
endmodule

// File: rtl/dma_cell_addr_gen_chk.sv
module dma_cell_addr_gen_chk #(
  parameter int NUM_CH   = 16,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int REG_AW   = 12,
  parameter int REG_BASE = 'h74,
  localparam int SEL_W   = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regRdData,
  input logic [NUM_CH-1:0] chEnable,
  input logic [SEL_W-1:0]  chSel,
  input logic              startPulse,
  input logic [ADDR_W-1:0] startAddr,
  input logic [ADDR_W-1:0] cellAddr,
  input logic [NUM_CH-1:0] cfgErr
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:STRIDE_W] == '0);

  a_r3_enabled_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn) && $past(chEnable[0]) && $past(regAddr) == REG_AW'(REG_BASE) &&
     regAddr == REG_AW'(REG_BASE)) |-> regRdData == $past(regRdData));

  a_r4_start_loads: assert property (@(posedge clk) disable iff (!rstN)
    ($past(startPulse) && $stable(chSel)) |-> cellAddr == $past(startAddr));

  a_r4_start_clears_err: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !cfgErr[$past(chSel)]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
      $fell(cfgErr[g]) |-> ($past(startPulse) && $past(chSel) == SEL_W'(g)));
  end
endmodule

bind dma_cell_addr_gen dma_cell_addr_gen_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STRIDE_W(STRIDE_W), .REG_AW(REG_AW), .REG_BASE(REG_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regRdData(regRdData), .chEnable(chEnable), .chSel(chSel),
  .startPulse(startPulse), .startAddr(startAddr), .cellAddr(cellAddr),
  .cfgErr(cfgErr)
);

// File: tb/sim_dma_cell_addr_gen.sv
`timescale 1ns/1ps
module sim_dma_cell_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] chEnable = '0;
  logic [3:0]  chSel = '0;
  logic        startPulse = 1'b0;
  logic [31:0] startAddr = '0;
  logic        cellDone = 1'b0;
  logic [15:0] cellSize = '0;
  logic [2:0]  widthCode = '0;
  logic        wordOnly = 1'b0;
  logic [31:0] cellAddr;
  logic [15:0] cfgErr;

  int nChecks = 0;
  int nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cell_addr_gen u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .chEnable(chEnable),
    .chSel(chSel), .startPulse(startPulse), .startAddr(startAddr),
    .cellDone(cellDone), .cellSize(cellSize), .widthCode(widthCode),
    .wordOnly(wordOnly), .cellAddr(cellAddr), .cfgErr(cfgErr)
  );

  function automatic logic [11:0] chAddr(input int ch);
    return 12'(32'h74 + ch * 32'h50);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic doStart(input int ch, input logic [31:0] a);
    @(negedge clk);
    chSel = 4'(ch); startAddr = a; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic doStep(input int ch, input logic [15:0] sz, input logic [2:0] wc, input logic wo);
    @(negedge clk);
    chSel = 4'(ch); cellSize = sz; widthCode = wc; wordOnly = wo; cellDone = 1'b1;
    @(negedge clk);
    cellDone = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] d;
    chSel = 4'd9;
    #1 check("R1 address", cellAddr, 32'h0);
    check("R1 cfgErr", 32'(cfgErr), 32'h0);
    rdReg(chAddr(3), d);
    check("R1 stride", d, 32'h0);
  endtask

  task automatic tRegAccess();
    logic [31:0] d;
    wrReg(chAddr(5), 32'h0000_1234);
    rdReg(chAddr(5), d);
    check("R2 readback ch5", d, 32'h0000_1234);
    wrReg(chAddr(15), 32'hABCD_5678);
    rdReg(chAddr(15), d);
    check("R2 upper bits zero ch15", d, 32'h0000_5678);
  endtask

  task automatic tProtect();
    logic [31:0] d;
    chEnable[5] = 1'b1;
    wrReg(chAddr(5), 32'h0000_9999);
    rdReg(chAddr(5), d);
    check("R3 enabled write ignored", d, 32'h0000_1234);
    chEnable[5] = 1'b0;
    wrReg(chAddr(6), 32'h0000_0001);
    chEnable[6] = 1'b1;
    rdReg(chAddr(6), d);
    check("R3 read while enabled", d, 32'h0000_0001);
    chEnable[6] = 1'b0;
  endtask

  task automatic tBadAddr();
    logic [31:0] d;
    wrReg(12'h076, 32'h0000_4444);
    rdReg(chAddr(0), d);
    check("R12 stray write no effect", d, 32'h0);
    rdReg(12'h076, d);
    check("R12 unmapped read", d, 32'h0);
  endtask

  task automatic tStep();
    doStart(5, 32'h0000_1000);
    check("R4 start load", cellAddr, 32'h0000_1000);
    doStep(5, 16'h0020, 3'b000, 1'b0);
    check("R5 first step", cellAddr, 32'h0000_2254);
    doStep(5, 16'h0020, 3'b000, 1'b0);
    check("R5 second step", cellAddr, 32'h0000_34A8);
  endtask

  task automatic tZeroStride();
    doStart(2, 32'h0000_0100);
    doStep(2, 16'h0040, 3'b000, 1'b0);
    check("R6 zero stride", cellAddr, 32'h0000_0180);
  endtask

  task automatic tHalfAlign();
    wrReg(chAddr(1), 32'h0000_0005);
    doStart(1, 32'h0);
    doStep(1, 16'h0010, 3'b001, 1'b0);
    check("R7 misaligned flag", 32'(cfgErr[1]), 32'h1);
    check("R7 address still advanced", cellAddr, 32'h0000_0015);
    doStep(1, 16'h0010, 3'b000, 1'b0);
    check("R7 sticky", 32'(cfgErr[1]), 32'h1);
    doStart(1, 32'h0);
    check("R4 start clears error", 32'(cfgErr[1]), 32'h0);
    wrReg(chAddr(1), 32'h0000_0004);
    doStep(1, 16'h0010, 3'b100, 1'b0);
    check("R7 aligned code 100", 32'(cfgErr[1]), 32'h0);
    wrReg(chAddr(1), 32'h0000_0003);
    doStep(1, 16'h0010, 3'b100, 1'b0);
    check("R7 misaligned code 100", 32'(cfgErr[1]), 32'h1);
  endtask

  task automatic tWordAlign();
    wrReg(chAddr(3), 32'h0000_0006);
    doStart(3, 32'h0);
    doStep(3, 16'h0008, 3'b101, 1'b0);
    check("R8 misaligned word", 32'(cfgErr[3]), 32'h1);
    wrReg(chAddr(3), 32'h0000_0004);
    doStart(3, 32'h0);
    doStep(3, 16'h0008, 3'b101, 1'b0);
    check("R8 aligned word", 32'(cfgErr[3]), 32'h0);
  endtask

  task automatic tCondAlign();
    wrReg(chAddr(4), 32'h0000_0002);
    doStart(4, 32'h0);
    doStep(4, 16'h0008, 3'b010, 1'b0);
    check("R9 code 010 without wordOnly", 32'(cfgErr[4]), 32'h0);
    doStep(4, 16'h0008, 3'b010, 1'b1);
    check("R9 code 010 with wordOnly", 32'(cfgErr[4]), 32'h1);
    wrReg(chAddr(6), 32'h0000_0001);
    doStart(6, 32'h0);
    doStep(6, 16'h0008, 3'b011, 1'b1);
    check("R9 other code never errs", 32'(cfgErr[6]), 32'h0);
  endtask

  task automatic tWrap();
    wrReg(chAddr(7), 32'h0000_0010);
    doStart(7, 32'hFFFF_FFF0);
    doStep(7, 16'h0008, 3'b000, 1'b0);
    check("R10 wrap", cellAddr, 32'h0000_0008);
  endtask

  task automatic tPriority();
    @(negedge clk);
    chSel = 4'd5; startAddr = 32'h0000_0777; cellSize = 16'h0020;
    startPulse = 1'b1; cellDone = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; cellDone = 1'b0;
    check("R11 start wins", cellAddr, 32'h0000_0777);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tRegAccess();
    tProtect();
    tBadAddr();
    tStep();
    tZeroStride();
    tHalfAlign();
    tWordAlign();
    tCondAlign();
    tWrap();
    tPriority();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule